// File: doc/BRIEF.md
# XOR Interleave Selector Bit Restorer

This block sits on a stream of 64-bit host physical addresses. It rewrites the interleave selector bits the way a memory window with XOR interleave arithmetic does. Software programs a small bank of XOR map registers and a control word. The control word holds the interleave ways count, how many maps are in use, and the arithmetic mode.

For each active map, in index order, the block finds the lowest set bit of the map. It then overwrites that address bit with the parity of the address ANDed with the map. A map works on the address as already changed by every map before it. A window in modulo mode skips the correction, and so does a ways count of 1 or 3. Addresses enter on a valid/ready port and leave one cycle later on a registered valid/ready port.

Top module: `xor_pos_restore`

## Requirements
- R1: After a synchronous reset, the output is empty and the input is ready. All maps read zero, the ways count is 1, the map count is 0 and the mode is modulo, so an address passes through unchanged.
- R2: When the control mode bit (bit 16 of the control word at configuration address 4) is 0 (modulo), every address is forwarded unchanged.
- R3: When the ways count (control bits 4:0) is 1 or 3, the address is forwarded unchanged even in XOR mode.
- R4: In XOR mode with ways count other than 1 or 3, each active map writes the address bit at the map's lowest set bit position with the XOR of all bits of (address AND map). No other address bit changes.
- R5: A map register holding zero leaves the address unchanged.
- R6: Maps apply in ascending index order, and each map sees the address produced by the maps with lower indices.
- R7: Only maps with index below the map count (control bits 10:8) are applied; maps at higher indices are ignored.
- R8: An accepted address appears at the output on the next cycle. Input ready is high when the output is empty or is being taken. A stalled output holds its value and valid.
- R9: A configuration write does not change the result of an address already accepted. This includes a write in the same cycle as the acceptance. The new settings apply from the next accepted address.
- R10: Map registers sit at configuration addresses 0 to 3; writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select: 0..3 maps, 4 control |
| cfg_wdata | input | 64 | Configuration write data |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Input address accepted when high with in_valid |
| in_addr | input | 64 | Input host physical address |
| out_valid | output | 1 | Output address valid |
| out_ready | input | 1 | Downstream ready |
| out_addr | output | 64 | Address with selector bits restored |

## Verification
The assertions assume that the downstream side takes a stalled word only by raising out_ready; they place no limit on how long a stall lasts. They also assume that configuration writes need no protocol of their own, because any write in any cycle is legal. The bench changes every input half a clock away from the rising edge. It tries configuration writes in the same cycle as an acceptance and during a stall, which are the cases where the in-flight result must keep the old settings.

// File: rtl/xpr_pkg.sv
package xpr_pkg;
  localparam int WAYS_W       = 5;
  localparam int CTRL_CNT_LSB = 8;
  localparam int CTRL_MODE_BIT = 16;

  typedef enum logic {
    ARITH_MODULO = 1'b0,
    ARITH_XOR    = 1'b1
  } arith_e;
endpackage

// File: rtl/xpr_cfg_regs.sv
module xpr_cfg_regs
  import xpr_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NUM_MAPS = 4,
  parameter int CFG_AW   = 3,
  parameter int CNT_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [CFG_AW-1:0]                waddr,
  input  logic [ADDR_W-1:0]                wdata,
  output logic [NUM_MAPS-1:0][ADDR_W-1:0]  maps,
  output logic [WAYS_W-1:0]                ways,
  output logic [CNT_W-1:0]                 map_cnt,
  output arith_e                           mode
);
  genvar g;
  generate
    for (g = 0; g < NUM_MAPS; g++) begin : g_map
      always_ff @(posedge clk) begin
        if (rst) begin
          maps[g] <= '0;
        end else if (we && (waddr == CFG_AW'(g))) begin
          maps[g] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ways    <= WAYS_W'(1);
      map_cnt <= '0;
      mode    <= ARITH_MODULO;
    end else if (we && (waddr == CFG_AW'(NUM_MAPS))) begin
      ways    <= wdata[WAYS_W-1:0];
      map_cnt <= wdata[CTRL_CNT_LSB +: CNT_W];
      mode    <= arith_e'(wdata[CTRL_MODE_BIT]);
    end
  end
endmodule

// File: rtl/xpr_map_stage.sv
module xpr_map_stage #(
  parameter int ADDR_W = 64
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] map,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] sel_bit;
  logic              parity;

  always_comb begin
    sel_bit = map & (~map + ADDR_W'(1));
    parity  = ^(addr_in & map);
    if (en) begin
      addr_out = (addr_in & ~sel_bit) | (parity ? sel_bit : '0);
    end else begin
      addr_out = addr_in;
    end
  end
endmodule

// File: rtl/xpr_out_reg.sv
module xpr_out_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/xor_pos_restore.sv
module xor_pos_restore
  import xpr_pkg::*;
#(
  parameter int  ADDR_W   = 64,
  parameter int  NUM_MAPS = 4,
  localparam int CFG_AW   = $clog2(NUM_MAPS + 1),
  localparam int CNT_W    = $clog2(NUM_MAPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  logic [NUM_MAPS-1:0][ADDR_W-1:0] map_q;
  logic [WAYS_W-1:0]               ways_q;
  logic [CNT_W-1:0]                cnt_q;
  arith_e                          mode_q;
  logic                            xor_active;
  logic [NUM_MAPS:0][ADDR_W-1:0]   chain;

  xpr_cfg_regs #(
    .ADDR_W(ADDR_W), .NUM_MAPS(NUM_MAPS), .CFG_AW(CFG_AW), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .maps(map_q), .ways(ways_q), .map_cnt(cnt_q), .mode(mode_q)
  );

  assign xor_active = (mode_q == ARITH_XOR) &&
                      (ways_q != WAYS_W'(1)) && (ways_q != WAYS_W'(3));
  assign chain[0] = in_addr;

  genvar i;
  generate
    for (i = 0; i < NUM_MAPS; i++) begin : g_stage
      xpr_map_stage #(.ADDR_W(ADDR_W)) u_stage (
        .en(xor_active && (cnt_q > CNT_W'(i))),
        .map(map_q[i]),
        .addr_in(chain[i]),
        .addr_out(chain[i+1])
      );
    end
  endgenerate

  xpr_out_reg #(.DATA_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(chain[NUM_MAPS]),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_addr)
  );
endmodule

// File: rtl/xpr_checker.sv
module xpr_checker
  import xpr_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NUM_MAPS = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            in_valid,
  input logic                            in_ready,
  input logic [ADDR_W-1:0]               in_addr,
  input logic                            out_valid,
  input logic                            out_ready,
  input logic [ADDR_W-1:0]               out_addr,
  input logic [NUM_MAPS-1:0][ADDR_W-1:0] maps,
  input logic [WAYS_W-1:0]               ways,
  input arith_e                          mode
);
  logic [ADDR_W-1:0] map_union;
  logic              accept;
  logic              bypass;

  always_comb begin
    map_union = '0;
    for (int k = 0; k < NUM_MAPS; k++) begin
      map_union = map_union | maps[k];
    end
  end

  assign accept = in_valid && in_ready;
  assign bypass = (mode == ARITH_MODULO) || (ways == WAYS_W'(1)) || (ways == WAYS_W'(3));

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)); // R8

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !accept && !out_valid |=> !out_valid); // R8

  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    accept && bypass |=> out_addr == $past(in_addr)); // R3

  AST_MAPPED_BITS_ONLY: assert property (@(posedge clk) disable iff (rst)
    accept |=> ((out_addr ^ $past(in_addr)) & ~$past(map_union)) == '0); // R4
endmodule

bind xor_pos_restore xpr_checker #(.ADDR_W(ADDR_W), .NUM_MAPS(NUM_MAPS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .maps(map_q), .ways(ways_q), .mode(mode_q)
);

// File: tb/tb_xor_pos_restore.sv
module tb_xor_pos_restore;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_addr;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] sh_map [4];
  int          sh_ways = 1;
  int          sh_cnt  = 0;
  bit          sh_xor  = 1'b0;

  always #5 clk = ~clk;

  xor_pos_restore dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] a);
    logic [63:0] r = a;
    if (!sh_xor || sh_ways == 1 || sh_ways == 3) return a;
    for (int i = 0; i < 4; i++) begin
      if (i < sh_cnt && sh_map[i] != 0) begin
        int k = 0;
        while (!sh_map[i][k]) k++;
        r[k] = ($countones(r & sh_map[i]) % 2) == 1;
      end
    end
    return r;
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4) sh_map[a] = d;
    else if (a == 4) begin
      sh_ways = int'(d[4:0]); sh_cnt = int'(d[10:8]); sh_xor = d[16];
    end
  endtask

  function automatic logic [63:0] ctrl(input int ways, input int cnt, input bit xm);
    return (64'(xm) << 16) | (64'(cnt) << 8) | 64'(ways);
  endfunction

  task automatic xfer(input logic [63:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
    check(out_addr === exp, tag, out_addr, exp);
  endtask

  task automatic t_reset;
    check(out_valid === 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready === 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
    xfer(64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, "R1 passthrough after reset");
  endtask

  task automatic t_single_map;
    cfg_write(3'd0, 64'h1100);
    cfg_write(3'd4, ctrl(2, 1, 1'b1));
    xfer(64'h1000, 64'h1100, "R4 bit8 set by odd parity");
    xfer(64'h1100, 64'h1000, "R4 bit8 cleared by even parity");
    xfer(64'hF0F0_0000_0000_1000, model(64'hF0F0_0000_0000_1000), "R4 high bits untouched");
    cfg_write(3'd3, 64'h8000_0000_0000_0001);
    cfg_write(3'd4, ctrl(8, 4, 1'b1));
    xfer(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, "R4 msb drives bit0");
    cfg_write(3'd3, 64'h0);
  endtask

  task automatic t_chain;
    cfg_write(3'd0, 64'h600);
    cfg_write(3'd1, 64'h300);
    cfg_write(3'd4, ctrl(4, 2, 1'b1));
    xfer(64'h400, 64'h700, "R6 second map sees first result");
    xfer(64'h1234_5678_9ABC_DEF0, model(64'h1234_5678_9ABC_DEF0), "R6 mixed address");
    cfg_write(3'd4, ctrl(4, 1, 1'b1));
    xfer(64'h400, 64'h600, "R7 map1 beyond count ignored");
    cfg_write(3'd4, ctrl(4, 0, 1'b1));
    xfer(64'h400, 64'h400, "R7 zero count applies none");
  endtask

  task automatic t_zero_map;
    cfg_write(3'd0, 64'h0);
    cfg_write(3'd1, 64'h300);
    cfg_write(3'd4, ctrl(16, 2, 1'b1));
    xfer(64'h200, 64'h300, "R5 zero map0 skipped, map1 applied");
    cfg_write(3'd1, 64'h0);
    xfer(64'hFFFF_0000_FFFF_0000, 64'hFFFF_0000_FFFF_0000, "R5 all zero maps");
  endtask

  task automatic t_bypass;
    cfg_write(3'd0, 64'h600);
    cfg_write(3'd1, 64'h300);
    cfg_write(3'd4, ctrl(3, 2, 1'b1));
    xfer(64'h400, 64'h400, "R3 ways 3 bypass");
    cfg_write(3'd4, ctrl(1, 2, 1'b1));
    xfer(64'h400, 64'h400, "R3 ways 1 bypass");
    cfg_write(3'd4, ctrl(4, 2, 1'b0));
    xfer(64'h400, 64'h400, "R2 modulo bypass");
    cfg_write(3'd4, ctrl(12, 2, 1'b1));
    xfer(64'h400, 64'h700, "R3 ways 12 uses maps");
  endtask

  task automatic t_unmapped;
    cfg_write(3'd5, 64'h0);
    cfg_write(3'd6, 64'h0);
    cfg_write(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    xfer(64'h400, 64'h700, "R10 writes to 5..7 ignored");
  endtask

  task automatic t_stall;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 64'h400; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 64'h1111;
    check(out_valid === 1'b1, "R8 valid one cycle later", 64'(out_valid), 64'd1);
    check(out_addr === 64'h700, "R8 result", out_addr, 64'h700);
    check(in_ready === 1'b0, "R8 not ready while stalled", 64'(in_ready), 64'd0);
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = ctrl(4, 2, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0; sh_xor = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_addr === 64'h700, "R9 stalled result kept after cfg write", out_addr, 64'h700);
    check(out_valid === 1'b1, "R8 valid held", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drained", 64'(out_valid), 64'd0);
    xfer(64'h400, 64'h400, "R9 new modulo setting applies");
  endtask

  task automatic t_same_cycle_cfg;
    cfg_write(3'd4, ctrl(4, 2, 1'b1));
    @(negedge clk);
    in_valid = 1'b1; in_addr = 64'h400; out_ready = 1'b1;
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = ctrl(4, 2, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0; sh_xor = 1'b0;
    check(out_addr === 64'h700, "R9 same-cycle write uses old settings", out_addr, 64'h700);
    xfer(64'h400, 64'h400, "R9 next address uses new settings");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) sh_map[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_map();
    t_chain();
    t_zero_map();
    t_bypass();
    t_unmapped();
    t_stall();
    t_same_cycle_cfg();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule